// File: doc/BRIEF.md
# Interrupt Acknowledge and Priority Interface

This block is the per-processor end of an interrupt controller. It watches a small, parameterized set of interrupt lines and tracks each one through a lifecycle with two state bits: one for pending and one for active. Each line has configuration inputs for enable, group, edge or level sensing, and priority. A global priority mask and two group enables complete the configuration. From the lines that qualify, the block picks one winner per group and raises a single request line towards the processor.

Software works the block through strobe ports shaped like register accesses:
- Acknowledge has one port per group. It returns an interrupt ID and makes that interrupt active.
- End-of-interrupt takes back the running priority.
- Deactivate returns an ID to idle.

Acknowledges push the running priority onto a short stack, and end-of-interrupt writes pop it. This lets a more urgent interrupt preempt a less urgent one while the less urgent one is being handled. A mode input selects how the last two steps work. In one setting, end-of-interrupt drops the priority and also deactivates the ID. In the other, it only drops the priority, and a separate deactivate write is needed.

Interrupt index i is reported as ID `ID_BASE + i`. The default base is 32, which places the IDs in the peripheral range. ID 1023 means "nothing to acknowledge".

Top module: `irq_cpu_if`

## Requirements
- R1: Each ID reports a 2-bit state on `id_state[2i+1:2i]`: 0 inactive, 1 pending, 2 active, 3 active-and-pending. A level input that is still high while its ID is active moves it to 3 on the cycle after the acknowledge.
- R2: An acknowledge that finds a qualifying interrupt returns `ID_BASE + index` on `ack_id` one cycle later and makes that ID active. An active ID is never acknowledged again until it has been deactivated.
- R3: `ack_rd[0]` returns only group-0 interrupts (`cfg_group` bit 0), and `ack_rd[1]` returns only group-1 interrupts. If both strobes are asserted together, group 0 is served.
- R4: An interrupt qualifies only when all of the following hold:
  - its group enable (`grp_en[g]`) is set;
  - its `cfg_enable` bit is set;
  - its priority value is numerically below `prio_mask`.
- R5: `irq_req` is high exactly when some interrupt qualifies in either group and the priority stack is not full. It is low after reset.
- R6: An interrupt qualifies only if its priority value is numerically below the current running priority. The running priority is the last acknowledged priority still on the stack, or "idle" (above every value) when the stack is empty.
- R7: With `eoi_mode`=0, an end-of-interrupt write pops the running priority and also returns `eoi_id` from active to inactive (or from active-and-pending to pending).
- R8: With `eoi_mode`=1, an end-of-interrupt write only pops the running priority, and `dir_wr` with `dir_id` deactivates the ID. With `eoi_mode`=0, `dir_wr` has no effect.
- R9: An acknowledge that finds nothing qualifying returns 1023 and changes no state.
- R10: A lower priority value is more urgent. Among equal values, the lowest index wins.
- R11: The running-priority stack holds 4 entries. While it is full, an acknowledge returns 1023 and `irq_req` stays low.
- R12: An end-of-interrupt write while the stack is empty is ignored: no pop and no deactivation. An acknowledge in the same cycle takes precedence over an end-of-interrupt write.
- R13: An ID whose `cfg_edge` bit is 1 latches pending on a rising edge of its line and keeps it until acknowledged. Otherwise pending follows the line.
- R14: After reset, every ID is inactive, `ack_id` is 1023 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line | input | NUM_ID | Raw interrupt lines, one per index |
| cfg_enable | input | NUM_ID | Per-ID enable |
| cfg_group | input | NUM_ID | Per-ID group: 0 or 1 |
| cfg_edge | input | NUM_ID | 1 = edge-triggered, 0 = level-sensitive |
| cfg_prio | input | NUM_ID*PRIO_W | Per-ID priority; index i occupies bits [i*PRIO_W +: PRIO_W] |
| grp_en | input | 2 | Group enables, bit g for group g |
| prio_mask | input | PRIO_W | Priority mask; a priority must be below it to qualify |
| eoi_mode | input | 1 | 0 = EOI drops and deactivates, 1 = EOI drops only |
| ack_rd | input | 2 | Acknowledge strobes, bit g for group g |
| ack_id | output | 10 | ID returned by the last acknowledge (1023 if spurious) |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID written with end-of-interrupt |
| dir_wr | input | 1 | Deactivate strobe |
| dir_id | input | 10 | ID written with deactivate |
| irq_req | output | 1 | Interrupt request to the processor |
| id_state | output | 2*NUM_ID | Lifecycle state per ID |

## Verification
The embedded assertions run on every cycle and check the following:
- an acknowledged ID becomes active;
- a level line held high through activity reaches active-and-pending;
- an edge-latched pending survives until acknowledged;
- the stack count never exceeds its depth and never goes below zero;
- a strobe with no winner returns 1023.

Other behaviour needs the bench's ordered scenarios:
- tie-breaking by lowest index;
- preemption against the running priority;
- the difference between the two end-of-interrupt modes;
- an ignored deactivate in mode 0;
- an ignored end-of-interrupt on an empty stack;
- the refusal to acknowledge once four levels are nested.

// File: rtl/irq_if_pkg.sv
// Shared constants and the per-ID lifecycle encoding for the interrupt interface.
package irq_if_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    // Bit 1 = active, bit 0 = pending.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } irq_state_e;
endpackage

// File: rtl/irq_cell.sv
// One interrupt's lifecycle: holds pending and active bits.
// Assumes ack_i is raised only for a pending, non-active ID, and deact_i only
// by the decoded end-of-interrupt or deactivate write.
module irq_cell import irq_if_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       edge_i,
    input  logic       ack_i,
    input  logic       deact_i,
    output irq_state_e state_o
);
    logic pend_q, act_q, line_q;

    // Track the line, latch or follow pending, and set or clear active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            act_q  <= 1'b0;
            line_q <= 1'b0;
        end else begin
            line_q <= line_i;
            if (ack_i)
                pend_q <= 1'b0;
            else if (edge_i)
                pend_q <= pend_q | (line_i & ~line_q);
            else
                pend_q <= line_i;
            if (ack_i)
                act_q <= 1'b1;
            else if (deact_i)
                act_q <= 1'b0;
        end
    end

    assign state_o = irq_state_e'({act_q, pend_q});

    a_r2_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> act_q);
    a_r1_active_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !deact_i && !ack_i && !edge_i && line_i) |=> (act_q && pend_q));
    a_r13_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/irq_pick.sv
// Picks the most urgent eligible interrupt whose priority is below a threshold.
// Equal priorities go to the lowest index. Assumes eligibility is pre-masked.
module irq_pick #(
    parameter int NUM_ID = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ID-1:0]        elig_i,
    input  logic [NUM_ID*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W:0]          thresh_i,
    output logic                     valid_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic [PRIO_W:0]          prio_o
);
    // Linear scan; strict compare keeps the earliest index on ties.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = thresh_i;
        for (int i = 0; i < NUM_ID; i++) begin
            if (elig_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
            end
        end
    end

    a_r4_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (elig_i[idx_o] && prio_o < thresh_i));
endmodule

// File: rtl/prio_stack.sv
// Running-priority history. Push on acknowledge, pop on end-of-interrupt.
// The running value is the top entry, or IDLE (all ones plus one) when empty.
// Push wins over pop; pushes while full and pops while empty are ignored.
module prio_stack #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [PRIO_W:0] push_val_i,
    input  logic            pop_i,
    output logic [PRIO_W:0] running_o,
    output logic            full_o,
    output logic            empty_o
);
    localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

    logic [PRIO_W:0] stk_q [DEPTH];
    logic [CW-1:0]   cnt_q;
    logic [SW-1:0]   top_idx;

    assign full_o    = (cnt_q == CW'(DEPTH));
    assign empty_o   = (cnt_q == '0);
    assign top_idx   = SW'(cnt_q - CW'(1));
    assign running_o = empty_o ? IDLE : stk_q[top_idx];

    // Write the new entry at the count and move the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= IDLE;
        end else if (push_i && !full_o) begin
            stk_q[cnt_q[SW-1:0]] <= push_val_i;
            cnt_q <= cnt_q + CW'(1);
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/irq_cpu_if.sv
// Per-processor interrupt interface. It qualifies the lines against enables,
// the mask and the running priority, and picks one winner per group. It serves
// acknowledge, end-of-interrupt and deactivate strobes.
// Assumes ID_BASE + NUM_ID <= 1020 and at most one EOI and one DIR per cycle.
module irq_cpu_if import irq_if_pkg::*; #(
    parameter int NUM_ID    = 8,
    parameter int PRIO_W    = 4,
    parameter int STK_DEPTH = 4,
    parameter int ID_BASE   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ID-1:0]        irq_line,
    input  logic [NUM_ID-1:0]        cfg_enable,
    input  logic [NUM_ID-1:0]        cfg_group,
    input  logic [NUM_ID-1:0]        cfg_edge,
    input  logic [NUM_ID*PRIO_W-1:0] cfg_prio,
    input  logic [1:0]               grp_en,
    input  logic [PRIO_W-1:0]        prio_mask,
    input  logic                     eoi_mode,
    input  logic [1:0]               ack_rd,
    output logic [ID_W-1:0]          ack_id,
    input  logic                     eoi_wr,
    input  logic [ID_W-1:0]          eoi_id,
    input  logic                     dir_wr,
    input  logic [ID_W-1:0]          dir_id,
    output logic                     irq_req,
    output logic [2*NUM_ID-1:0]      id_state
);
    localparam int IDX_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1;

    irq_state_e       st    [NUM_ID];
    logic [NUM_ID-1:0] elig [2];
    logic [1:0]        pick_valid;
    logic [IDX_W-1:0]  pick_idx [2];
    logic [PRIO_W:0]   pick_prio [2];
    logic [PRIO_W:0]   running, thresh, mask_ext;
    logic              stk_full, stk_empty;
    logic [1:0]        ack_go;
    logic              push, pop;
    logic [PRIO_W:0]   push_val;

    // The effective threshold is the tighter of the mask and the running priority.
    assign mask_ext = {1'b0, prio_mask};
    assign thresh   = (mask_ext < running) ? mask_ext : running;

    // Per-group picker; a group sees only its own pending, idle, enabled IDs.
    for (genvar g = 0; g < 2; g++) begin : g_grp
        for (genvar i = 0; i < NUM_ID; i++) begin : g_el
            assign elig[g][i] = (st[i] == ST_PEND) && cfg_enable[i] && grp_en[g]
                                && (cfg_group[i] == 1'(g));
        end
        irq_pick #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) u_pick (
            .clk(clk), .rst_n(rst_n), .elig_i(elig[g]), .prio_i(cfg_prio),
            .thresh_i(thresh), .valid_o(pick_valid[g]), .idx_o(pick_idx[g]),
            .prio_o(pick_prio[g]));
    end

    // Group 0 wins a simultaneous strobe; a full stack refuses every acknowledge.
    assign ack_go[0] = ack_rd[0] && pick_valid[0] && !stk_full;
    assign ack_go[1] = ack_rd[1] && !ack_rd[0] && pick_valid[1] && !stk_full;
    assign push      = |ack_go;
    assign push_val  = ack_go[0] ? pick_prio[0] : pick_prio[1];
    assign pop       = eoi_wr && !push && !stk_empty;
    assign irq_req   = (|pick_valid) && !stk_full;

    prio_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_val_i(push_val),
        .pop_i(pop), .running_o(running), .full_o(stk_full), .empty_o(stk_empty));

    // Per-ID cells with decoded acknowledge and deactivate.
    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
        localparam logic [ID_W-1:0] MY_ID = ID_W'(ID_BASE + i);
        logic ack_me, deact_me;
        assign ack_me   = (ack_go[0] && pick_idx[0] == IDX_W'(i))
                       || (ack_go[1] && pick_idx[1] == IDX_W'(i));
        assign deact_me = (pop && !eoi_mode && eoi_id == MY_ID)
                       || (dir_wr && eoi_mode && dir_id == MY_ID);
        irq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .line_i(irq_line[i]), .edge_i(cfg_edge[i]),
            .ack_i(ack_me), .deact_i(deact_me), .state_o(st[i]));
        assign id_state[2*i +: 2] = st[i];
    end

    // Register the acknowledge result; a strobe without a winner gives the spurious ID.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_id <= SPURIOUS_ID;
        else if (ack_rd[0])
            ack_id <= ack_go[0] ? ID_W'(ID_BASE) + ID_W'(pick_idx[0]) : SPURIOUS_ID;
        else if (ack_rd[1])
            ack_id <= ack_go[1] ? ID_W'(ID_BASE) + ID_W'(pick_idx[1]) : SPURIOUS_ID;
    end

    a_r9_spurious_g0: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd[0] && !pick_valid[0]) |=> (ack_id == SPURIOUS_ID));
    a_r5_req_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !stk_full);
endmodule

// File: tb/sim_irq_cpu_if.sv
`timescale 1ns/1ps
module sim_irq_cpu_if;
    localparam int N = 8;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_line = '0, cfg_enable = '1, cfg_group = 8'hF0, cfg_edge = 8'h24;
    // priorities by index 0..7: 8,4,4,12,6,2,10,6
    logic [N*PW-1:0] cfg_prio = {4'd6, 4'd10, 4'd2, 4'd6, 4'd12, 4'd4, 4'd4, 4'd8};
    logic [1:0] grp_en = 2'b11;
    logic [PW-1:0] prio_mask = 4'd15;
    logic eoi_mode = 1'b0;
    logic [1:0] ack_rd = '0;
    logic [9:0] ack_id;
    logic eoi_wr = 1'b0, dir_wr = 1'b0;
    logic [9:0] eoi_id = '0, dir_id = '0;
    logic irq_req;
    logic [2*N-1:0] id_state;

    int n_run = 0, n_fail = 0;
    int q_exp[$];
    string q_tag[$];
    logic chk_pend = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_cpu_if u0 (.clk(clk), .rst_n(rst_n), .irq_line(irq_line), .cfg_enable(cfg_enable),
        .cfg_group(cfg_group), .cfg_edge(cfg_edge), .cfg_prio(cfg_prio), .grp_en(grp_en),
        .prio_mask(prio_mask), .eoi_mode(eoi_mode), .ack_rd(ack_rd), .ack_id(ack_id),
        .eoi_wr(eoi_wr), .eoi_id(eoi_id), .dir_wr(dir_wr), .dir_id(dir_id),
        .irq_req(irq_req), .id_state(id_state));

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic int st(int i);
        return int'(id_state[2*i +: 2]);
    endfunction

    // Driver: pulse an acknowledge strobe and queue the expected ID.
    task automatic ack(int g, int exp, string tag);
        ack_rd[g] = 1'b1;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        step();
        ack_rd = '0;
    endtask

    task automatic eoi(int id);
        eoi_wr = 1'b1; eoi_id = 10'(id);
        step();
        eoi_wr = 1'b0;
    endtask

    task automatic dir(int id);
        dir_wr = 1'b1; dir_id = 10'(id);
        step();
        dir_wr = 1'b0;
    endtask

    // Monitor: note a strobe at the edge, compare the returned ID half a cycle later.
    always @(posedge clk) chk_pend <= |ack_rd;
    always @(negedge clk) begin
        if (chk_pend) begin
            if (q_exp.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard: ack %0d with no expectation", ack_id);
            end else begin
                check(q_tag.pop_front(), int'(ack_id), q_exp.pop_front());
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        check("R14 irq_req", int'(irq_req), 0);
        check("R14 states", int'(id_state), 0);
        check("R14 ack_id", int'(ack_id), 1023);
        ack(0, 1023, "R9 empty ack");
        check("R9 states unchanged", int'(id_state), 0);

        // Tie between index 1 (level) and 2 (edge), both priority 4.
        irq_line[1] = 1; irq_line[2] = 1; step(); irq_line[2] = 0; step();
        check("R5 irq_req", int'(irq_req), 1);
        ack(0, 33, "R10 tie lowest index");
        step();
        check("R1 active-and-pending", st(1), 3);
        check("R6 equal prio no req", int'(irq_req), 0);
        ack(0, 1023, "R6 no preempt at equal prio");
        eoi(33);
        check("R7 eoi mode0 deactivates", st(1), 1);
        ack(0, 33, "R2 re-ack after deactivate");
        irq_line[1] = 0; step();
        check("R2 active", st(1), 2);
        eoi(33);
        check("R7 back to inactive", st(1), 0);
        ack(0, 34, "R13 edge latched");
        eoi(34);
        check("R7 edge id inactive", st(2), 0);

        irq_line[3] = 1; step(); irq_line[3] = 0; step();
        check("R13 level not latched", st(3), 0);
        ack(0, 1023, "R13 level pulse gone");

        // Mode 1: priority drop only.
        eoi_mode = 1; irq_line[0] = 1; step();
        ack(0, 32, "R8 ack id0");
        eoi(32);
        check("R8 still active", st(0), 3);
        ack(0, 1023, "R8 active not re-acked");
        dir(32);
        check("R8 dir deactivates", st(0), 1);
        ack(0, 32, "R8 after dir");
        irq_line[0] = 0; eoi(32); dir(32);
        check("R8 id0 idle", st(0), 0);

        // Groups.
        irq_line[4] = 1; step();
        check("R3 req grp1", int'(irq_req), 1);
        ack(0, 1023, "R3 group0 port blind to group1");
        ack(1, 36, "R3 group1 port");
        irq_line[4] = 0; eoi(36); dir(36);

        // Enables and mask.
        grp_en = 2'b10; irq_line[3] = 1; step();
        check("R4 group disabled", int'(irq_req), 0);
        ack(0, 1023, "R4 group disabled ack");
        grp_en = 2'b11; prio_mask = 4'd12; step();
        check("R4 mask equal blocks", int'(irq_req), 0);
        prio_mask = 4'd13; step();
        check("R4 mask passes", int'(irq_req), 1);
        cfg_enable[3] = 0; step();
        check("R4 id disabled", int'(irq_req), 0);
        cfg_enable[3] = 1;
        ack(0, 35, "R4 enabled ack");
        irq_line[3] = 0; eoi(35); dir(35);
        prio_mask = 4'd15;

        // Preemption, mode 0.
        eoi_mode = 0; irq_line[6] = 1; step();
        ack(1, 38, "R6 first");
        irq_line[4] = 1; step();
        ack(1, 36, "R6 preempt");
        irq_line[7] = 1; step();
        ack(1, 1023, "R6 equal to running");
        irq_line[4] = 0; step();
        eoi(36);
        check("R7 id4 idle", st(4), 0);
        ack(1, 39, "R6 after drop");
        irq_line[7] = 0; irq_line[6] = 0; step();
        eoi(39); eoi(38);
        check("R7 id7 idle", st(7), 0);
        check("R7 id6 idle", st(6), 0);

        // Stack depth.
        irq_line[3] = 1; step(); ack(0, 35, "R11 level1");
        irq_line[6] = 1; step(); ack(1, 38, "R11 level2");
        irq_line[0] = 1; step(); ack(0, 32, "R11 level3");
        irq_line[4] = 1; step(); ack(1, 36, "R11 level4");
        irq_line[1] = 1; step();
        check("R11 full no req", int'(irq_req), 0);
        ack(0, 1023, "R11 full ack spurious");
        irq_line[3] = 0; irq_line[6] = 0; irq_line[0] = 0; irq_line[4] = 0; step();
        eoi(36);
        ack(0, 33, "R11 room again");
        irq_line[1] = 0;
        eoi(33); eoi(32); eoi(38); eoi(35);
        check("R11 all idle", int'(id_state), 0);

        // EOI on an empty stack, and DIR in mode 0.
        eoi_mode = 1; irq_line[0] = 1; step();
        ack(0, 32, "R12 setup");
        eoi(32);
        eoi_mode = 0;
        eoi(32);
        check("R12 empty eoi ignored", st(0), 3);
        dir(32);
        check("R8 dir ignored mode0", st(0), 3);
        eoi_mode = 1;
        dir(32);
        check("R8 dir mode1", st(0), 1);
        ack(0, 32, "R12 reack");
        irq_line[0] = 0; eoi(32); dir(32);

        // Two edges collapse into one pending.
        eoi_mode = 0;
        irq_line[5] = 1; step(); irq_line[5] = 0; step();
        irq_line[5] = 1; step(); irq_line[5] = 0; step();
        ack(1, 37, "R13 edge ack");
        ack(1, 1023, "R13 single latch");
        eoi(37);
        check("R13 edge idle", st(5), 0);
        step(2);
        if (q_exp.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard: %0d pending expectations, expected 0", q_exp.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule